// File: doc/BRIEF.md
# Memory Controller Operating-State Machine

This block is the top-level operating-state machine of a DRAM protocol controller. A host presents a transition command (a one-cycle strobe with a three-bit code). The block walks through a transient request state and waits there for an acknowledge from the downstream engine responsible for that step. Only then does it settle in the target state. A status word reports the current state. While the controller sits in low power, the status word also reports what caused low power.

Low power is entered in one of two ways: a software sleep command, or a hardware path. The hardware path is armed by an enable pin and fired by an idle indication. When hardware caused low power, the software wake command is refused. Exit then follows the idle indication dropping. User traffic is allowed only while the machine is in the access state. DRAM commands, refresh and power-down timing live outside this block, behind the request/acknowledge pairs.

Top module: `msm_opstate`

## Requirements
- R1: After reset the state is init_mem, status reads 0, every request output is low and user access is disabled.
- R2: Command code 1 (config) in init_mem or access moves to config_req (state code 2), which holds until cfg_ack and then moves to config (code 1).
- R3: Command code 2 (go) in config moves to access_req (code 4), which holds until acc_ack and then moves to access (code 3).
- R4: Command code 3 (sleep) in access moves to lp_entry_req (code 6), then to low_power (code 5) on lpe_ack, with trigger value 2 (software).
- R5: Command code 4 (wakeup) in a software-triggered low_power moves to lp_exit_req (code 7), then to access on lpx_ack.
- R6: In access, with hw_lp_en high and hw_idle high, the machine enters lp_entry_req without any command, and reaches low_power with trigger value 1 (hardware). With hw_lp_en low, hw_idle has no effect.
- R7: In a hardware-triggered low_power the wakeup command is ignored. The machine moves to lp_exit_req when hw_idle falls.
- R8: Command code 0 (init) in config returns the machine to init_mem in one step.
- R9: Commands not legal in the current state are ignored and leave the state unchanged. This covers go or sleep in init_mem, sleep in config, config in low_power, any command in a request state, and codes 5 to 7.
- R10: Each request output (cfg_req, acc_req, lpe_req, lpx_req) is high exactly while the machine is in its request state (codes 2, 4, 6, 7). An acknowledge received in any other state has no effect. A request state lasts at least one cycle.
- R11: user_access_en is high only in the access state.
- R12: The status layout is: bits 2:0 hold the state code, bit 3 is 0, and bits 6:4 hold the trigger while in low_power. Bits 6:4 are 0 in every other state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_code | input | 3 | Transition command code |
| hw_lp_en | input | 1 | Arms hardware-triggered low-power entry |
| hw_idle | input | 1 | Idle indication that starts and holds hardware low power |
| cfg_ack | input | 1 | Acknowledge for config_req |
| acc_ack | input | 1 | Acknowledge for access_req |
| lpe_ack | input | 1 | Acknowledge for low-power entry |
| lpx_ack | input | 1 | Acknowledge for low-power exit |
| cfg_req | output | 1 | Config entry request |
| acc_req | output | 1 | Access entry request |
| lpe_req | output | 1 | Low-power entry request |
| lpx_req | output | 1 | Low-power exit request |
| user_access_en | output | 1 | User traffic allowed |
| status | output | 7 | State code and low-power trigger |

## Verification
The bench checks that a request state holds when the wrong acknowledge arrives. A design that decodes the acks loosely would leave config_req early. It sends a wakeup into a hardware-triggered low power, which a careless design would honour and so wake the memory behind the hardware's back. It also raises hw_idle with the enable low, and sends illegal commands such as go from init_mem, sleep from config and the unused code 5. A design with a permissive decoder would jump to the wrong state in these cases. Finally, it confirms that the trigger field appears only in low_power: reads 2 after a sleep and 1 after hardware entry, and clears on exit.

// File: rtl/msm_pkg.sv
package msm_pkg;
  localparam int ST_W   = 3;
  localparam int CMD_W  = 3;
  localparam int TRIG_W = 3;

  typedef enum logic [ST_W-1:0] {
    ST_INIT_MEM = 3'd0,
    ST_CONFIG   = 3'd1,
    ST_CFG_REQ  = 3'd2,
    ST_ACCESS   = 3'd3,
    ST_ACC_REQ  = 3'd4,
    ST_LOW_PWR  = 3'd5,
    ST_LPE_REQ  = 3'd6,
    ST_LPX_REQ  = 3'd7
  } msm_state_e;

  localparam logic [CMD_W-1:0] CMD_INIT   = 3'd0;
  localparam logic [CMD_W-1:0] CMD_CONFIG = 3'd1;
  localparam logic [CMD_W-1:0] CMD_GO     = 3'd2;
  localparam logic [CMD_W-1:0] CMD_SLEEP  = 3'd3;
  localparam logic [CMD_W-1:0] CMD_WAKE   = 3'd4;

  localparam logic [TRIG_W-1:0] TRIG_NONE = 3'd0;
  localparam logic [TRIG_W-1:0] TRIG_HW   = 3'd1;
  localparam logic [TRIG_W-1:0] TRIG_SW   = 3'd2;
endpackage

// File: rtl/msm_cmd_decode.sv
module msm_cmd_decode
  import msm_pkg::*;
(
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  msm_state_e        state,
  input  logic [TRIG_W-1:0] trig,
  output logic              do_cfg,
  output logic              do_go,
  output logic              do_sleep,
  output logic              do_wake,
  output logic              do_init
);
  logic in_init, in_cfg, in_acc, in_lp;

  assign in_init = (state == ST_INIT_MEM);
  assign in_cfg  = (state == ST_CONFIG);
  assign in_acc  = (state == ST_ACCESS);
  assign in_lp   = (state == ST_LOW_PWR);

  // Each strobe is the command qualified by the states that accept it.
  always_comb begin
    do_cfg   = 1'b0;
    do_go    = 1'b0;
    do_sleep = 1'b0;
    do_wake  = 1'b0;
    do_init  = 1'b0;
    if (cmd_valid) begin
      unique case (cmd_code)
        CMD_CONFIG: do_cfg   = in_init | in_acc;
        CMD_GO:     do_go    = in_cfg;
        CMD_SLEEP:  do_sleep = in_acc;
        CMD_WAKE:   do_wake  = in_lp & (trig != TRIG_HW);
        CMD_INIT:   do_init  = in_cfg;
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/msm_state_core.sv
module msm_state_core
  import msm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              do_cfg,
  input  logic              do_go,
  input  logic              do_sleep,
  input  logic              do_wake,
  input  logic              do_init,
  input  logic              hw_lp_en,
  input  logic              hw_idle,
  input  logic              cfg_ack,
  input  logic              acc_ack,
  input  logic              lpe_ack,
  input  logic              lpx_ack,
  input  logic [TRIG_W-1:0] trig,
  output msm_state_e        state,
  output logic              set_hw,
  output logic              set_sw,
  output logic              clr_trig
);
  msm_state_e nxt;

  always_comb begin
    nxt      = state;
    set_hw   = 1'b0;
    set_sw   = 1'b0;
    clr_trig = 1'b0;
    unique case (state)
      ST_INIT_MEM: if (do_cfg) nxt = ST_CFG_REQ;
      ST_CFG_REQ:  if (cfg_ack) nxt = ST_CONFIG;
      ST_CONFIG: begin
        if (do_go)        nxt = ST_ACC_REQ;
        else if (do_init) nxt = ST_INIT_MEM;
      end
      ST_ACC_REQ:  if (acc_ack) nxt = ST_ACCESS;
      ST_ACCESS: begin
        if (hw_lp_en && hw_idle) begin
          nxt    = ST_LPE_REQ;
          set_hw = 1'b1;
        end else if (do_sleep) begin
          nxt    = ST_LPE_REQ;
          set_sw = 1'b1;
        end else if (do_cfg) begin
          nxt = ST_CFG_REQ;
        end
      end
      ST_LPE_REQ:  if (lpe_ack) nxt = ST_LOW_PWR;
      ST_LOW_PWR: begin
        if (trig == TRIG_HW) begin
          if (!hw_idle) nxt = ST_LPX_REQ;
        end else if (do_wake) begin
          nxt = ST_LPX_REQ;
        end
      end
      ST_LPX_REQ: begin
        if (lpx_ack) begin
          nxt      = ST_ACCESS;
          clr_trig = 1'b1;
        end
      end
      default: nxt = ST_INIT_MEM;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) state <= ST_INIT_MEM;
    else        state <= nxt;
  end
endmodule

// File: rtl/msm_trig_reg.sv
module msm_trig_reg
  import msm_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_hw,
  input  logic              set_sw,
  input  logic              clr_trig,
  output logic [TRIG_W-1:0] trig
);
  always_ff @(posedge clk) begin
    if (!rst_n)        trig <= TRIG_NONE;
    else if (set_hw)   trig <= TRIG_HW;
    else if (set_sw)   trig <= TRIG_SW;
    else if (clr_trig) trig <= TRIG_NONE;
  end
endmodule

// File: rtl/msm_opstate.sv
module msm_opstate
  import msm_pkg::*;
#(
  parameter int N_REQ  = 4,
  localparam int STAT_W = ST_W + 1 + TRIG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [CMD_W-1:0]  cmd_code,
  input  logic              hw_lp_en,
  input  logic              hw_idle,
  input  logic              cfg_ack,
  input  logic              acc_ack,
  input  logic              lpe_ack,
  input  logic              lpx_ack,
  output logic              cfg_req,
  output logic              acc_req,
  output logic              lpe_req,
  output logic              lpx_req,
  output logic              user_access_en,
  output logic [STAT_W-1:0] status
);
  msm_state_e        state;
  logic [TRIG_W-1:0] trig;
  logic do_cfg, do_go, do_sleep, do_wake, do_init;
  logic set_hw, set_sw, clr_trig;
  logic [N_REQ-1:0] req_vec;

  msm_cmd_decode u_dec (
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .state     (state),
    .trig      (trig),
    .do_cfg    (do_cfg),
    .do_go     (do_go),
    .do_sleep  (do_sleep),
    .do_wake   (do_wake),
    .do_init   (do_init)
  );

  msm_state_core u_core (
    .clk      (clk),
    .rst_n    (rst_n),
    .do_cfg   (do_cfg),
    .do_go    (do_go),
    .do_sleep (do_sleep),
    .do_wake  (do_wake),
    .do_init  (do_init),
    .hw_lp_en (hw_lp_en),
    .hw_idle  (hw_idle),
    .cfg_ack  (cfg_ack),
    .acc_ack  (acc_ack),
    .lpe_ack  (lpe_ack),
    .lpx_ack  (lpx_ack),
    .trig     (trig),
    .state    (state),
    .set_hw   (set_hw),
    .set_sw   (set_sw),
    .clr_trig (clr_trig)
  );

  msm_trig_reg u_trig (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_hw   (set_hw),
    .set_sw   (set_sw),
    .clr_trig (clr_trig),
    .trig     (trig)
  );

  // Request outputs: one per transient state, in the order cfg, acc, lpe, lpx.
  localparam msm_state_e REQ_ST [N_REQ] = '{ST_CFG_REQ, ST_ACC_REQ, ST_LPE_REQ, ST_LPX_REQ};
  for (genvar g = 0; g < N_REQ; g++) begin : g_req
    assign req_vec[g] = (state == REQ_ST[g]);
  end
  assign cfg_req = req_vec[0];
  assign acc_req = req_vec[1];
  assign lpe_req = req_vec[2];
  assign lpx_req = req_vec[3];

  assign user_access_en = (state == ST_ACCESS);
  assign status = {(state == ST_LOW_PWR) ? trig : TRIG_NONE, 1'b0, state};
endmodule

// File: rtl/msm_opstate_chk.sv
module msm_opstate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       hw_idle,
  input logic       cfg_ack,
  input logic       acc_ack,
  input logic       lpx_ack,
  input logic       cfg_req,
  input logic       acc_req,
  input logic       lpe_req,
  input logic       lpx_req,
  input logic       user_access_en,
  input logic [6:0] status
);
  // R11
  access_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    user_access_en |-> (status[2:0] == 3'd3));
  // R10
  one_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cfg_req, acc_req, lpe_req, lpx_req}));
  // R2
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2:0] == 3'd2 && !cfg_ack) |=> (status[2:0] == 3'd2));
  // R3
  go_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2:0] == 3'd4 && acc_ack) |=> (status[2:0] == 3'd3));
  // R5
  wake_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[2:0] == 3'd7 && lpx_ack) |=> (status[2:0] == 3'd3));
  // R7
  hw_lp_stay_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == 7'h15 && hw_idle) |=> (status[2:0] == 3'd5));
  // R12
  spare_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status[3] == 1'b0));
endmodule

bind msm_opstate msm_opstate_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .hw_idle        (hw_idle),
  .cfg_ack        (cfg_ack),
  .acc_ack        (acc_ack),
  .lpx_ack        (lpx_ack),
  .cfg_req        (cfg_req),
  .acc_req        (acc_req),
  .lpe_req        (lpe_req),
  .lpx_req        (lpx_req),
  .user_access_en (user_access_en),
  .status         (status)
);

// File: tb/msm_opstate_bench.sv
module msm_opstate_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic hw_lp_en = 1'b0, hw_idle = 1'b0;
  logic cfg_ack = 1'b0, acc_ack = 1'b0, lpe_ack = 1'b0, lpx_ack = 1'b0;
  logic cfg_req, acc_req, lpe_req, lpx_req, user_access_en;
  logic [6:0] status;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  msm_opstate u_msm_opstate (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .hw_lp_en(hw_lp_en), .hw_idle(hw_idle),
    .cfg_ack(cfg_ack), .acc_ack(acc_ack), .lpe_ack(lpe_ack), .lpx_ack(lpx_ack),
    .cfg_req(cfg_req), .acc_req(acc_req), .lpe_req(lpe_req), .lpx_req(lpx_req),
    .user_access_en(user_access_en), .status(status)
  );

  // Vector: valid, code, acks {cfg,acc,lpe,lpx}, hw_lp_en, hw_idle, expected status, expected access
  localparam int NV = 27;
  localparam logic [17:0] VEC [NV] = '{
    {1'b1, 3'd2, 4'b0000, 1'b0, 1'b0, 7'h00, 1'b0}, // R9 go in init_mem
    {1'b1, 3'd3, 4'b0000, 1'b0, 1'b0, 7'h00, 1'b0}, // R9 sleep in init_mem
    {1'b1, 3'd1, 4'b0000, 1'b0, 1'b0, 7'h02, 1'b0}, // R2
    {1'b0, 3'd0, 4'b0001, 1'b0, 1'b0, 7'h02, 1'b0}, // R10 wrong ack
    {1'b0, 3'd0, 4'b1000, 1'b0, 1'b0, 7'h01, 1'b0}, // R2
    {1'b1, 3'd3, 4'b0000, 1'b0, 1'b0, 7'h01, 1'b0}, // R9 sleep in config
    {1'b1, 3'd2, 4'b0000, 1'b0, 1'b0, 7'h04, 1'b0}, // R3
    {1'b0, 3'd0, 4'b0100, 1'b0, 1'b0, 7'h03, 1'b1}, // R3 R11
    {1'b1, 3'd1, 4'b0000, 1'b0, 1'b0, 7'h02, 1'b0}, // R2 from access
    {1'b0, 3'd0, 4'b1000, 1'b0, 1'b0, 7'h01, 1'b0},
    {1'b1, 3'd2, 4'b0000, 1'b0, 1'b0, 7'h04, 1'b0},
    {1'b0, 3'd0, 4'b0100, 1'b0, 1'b0, 7'h03, 1'b1},
    {1'b1, 3'd3, 4'b0000, 1'b0, 1'b0, 7'h06, 1'b0}, // R4
    {1'b0, 3'd0, 4'b0010, 1'b0, 1'b0, 7'h25, 1'b0}, // R4 R12 trigger 2
    {1'b1, 3'd1, 4'b0000, 1'b0, 1'b0, 7'h25, 1'b0}, // R9 config in low_power
    {1'b1, 3'd4, 4'b0000, 1'b0, 1'b0, 7'h07, 1'b0}, // R5
    {1'b0, 3'd0, 4'b0001, 1'b0, 1'b0, 7'h03, 1'b1}, // R5
    {1'b0, 3'd0, 4'b0000, 1'b1, 1'b1, 7'h06, 1'b0}, // R6
    {1'b0, 3'd0, 4'b0010, 1'b1, 1'b1, 7'h15, 1'b0}, // R6 trigger 1
    {1'b1, 3'd4, 4'b0000, 1'b1, 1'b1, 7'h15, 1'b0}, // R7 wake refused
    {1'b0, 3'd0, 4'b0000, 1'b1, 1'b0, 7'h07, 1'b0}, // R7 idle falls
    {1'b0, 3'd0, 4'b0001, 1'b1, 1'b0, 7'h03, 1'b1}, // R7 R12 trigger cleared
    {1'b0, 3'd0, 4'b0000, 1'b0, 1'b1, 7'h03, 1'b1}, // R6 enable low
    {1'b1, 3'd1, 4'b0000, 1'b0, 1'b0, 7'h02, 1'b0},
    {1'b0, 3'd0, 4'b1000, 1'b0, 1'b0, 7'h01, 1'b0},
    {1'b1, 3'd0, 4'b0000, 1'b0, 1'b0, 7'h00, 1'b0}, // R8
    {1'b1, 3'd5, 4'b0000, 1'b0, 1'b0, 7'h00, 1'b0}  // R9 unused code
  };

  function automatic logic [3:0] req_for(input logic [2:0] st);
    return {st == 3'd2, st == 3'd4, st == 3'd6, st == 3'd7};
  endfunction

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [17:0] v);
    cmd_valid = v[17];
    cmd_code  = v[16:14];
    {cfg_ack, acc_ack, lpe_ack, lpx_ack} = v[13:10];
    hw_lp_en  = v[9];
    hw_idle   = v[8];
  endtask

  task automatic check_all(input string tag, input logic [6:0] es, input logic ea);
    check({tag, " status"}, {9'd0, status}, {9'd0, es});
    check({tag, " access R11"}, {15'd0, user_access_en}, {15'd0, ea});
    check({tag, " reqs R10"}, {12'd0, cfg_req, acc_req, lpe_req, lpx_req}, {12'd0, req_for(es[2:0])});
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    check_all("R1 reset", 7'h00, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i]);
      @(negedge clk);
      check_all($sformatf("vector %0d", i), VEC[i][7:1], VEC[i][0]);
    end
    // R1: reset from access returns to init_mem
    drive({1'b1, 3'd1, 4'b0000, 2'b00, 8'h00}); @(negedge clk);
    drive({1'b0, 3'd0, 4'b1000, 2'b00, 8'h00}); @(negedge clk);
    drive({1'b1, 3'd2, 4'b0000, 2'b00, 8'h00}); @(negedge clk);
    drive({1'b0, 3'd0, 4'b0100, 2'b00, 8'h00}); @(negedge clk);
    check_all("R3 access again", 7'h03, 1'b1);
    drive(18'd0);
    rst_n = 1'b0;
    @(negedge clk);
    check_all("R1 mid-run reset", 7'h00, 1'b0);
    rst_n = 1'b1;
    // R10: request state holds with no ack for several cycles
    drive({1'b1, 3'd1, 4'b0000, 2'b00, 8'h00}); @(negedge clk);
    drive({1'b0, 3'd0, 4'b0110, 2'b00, 8'h00});
    for (int k = 0; k < 3; k++) @(negedge clk);
    check_all("R10 hold under foreign acks", 7'h02, 1'b0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    for (int c = 0; c < 5000; c++) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule